// File: doc/BRIEF.md
# Channel Register File with Group Write Windows

This block stores the control registers for a four-channel datapath. Each channel owns an identical bank of 32 byte-wide registers, and one more bank of 32 bytes is common to all channels. A host register port reaches all of them through an 8-bit address. The port carries an address, write data, a write strobe and a read strobe. It is driven by a serial-bus target front end that sits outside this block. Every register bit is also presented on wide parallel output buses, so the datapath can use the settings without any read cycle.

The upper three address bits pick a window and the lower five bits pick a register inside it. Some windows reach a single channel, and one reaches the common bank. The remaining windows are group windows. A write to a group window lands at the same offset in a fixed set of channels on one clock edge. A read from a group window is steered to one designated channel of that set.

The port has no back-pressure. It is ready on every cycle, and the two strobes act as the valid qualifiers for a transfer. A new transfer may therefore be issued on every clock, which is far faster than a 400 kHz serial bus can supply bytes. Read results flow out with a one-cycle valid pulse and cannot be stalled.

Top module: `chan_regfile`

## Requirements
- R1: After a synchronous active-high reset, every channel register and every common register reads 0x00, and `rd_valid` is low.
- R2: A write to window 0, 1, 2 or 3 (address bits [7:5]) stores `wdata` at offset `addr[4:0]` of that channel only. No other channel register and no common register changes.
- R3: A write to window 4 (0x80–0x9F) stores the byte at that offset in channels 0, 1, 2 and 3. A read from window 4 returns channel 0's register.
- R4: A write to window 5 (0xA0–0xBF) stores the byte at that offset in channels 0 and 1 only. A read from window 5 returns channel 0's register.
- R5: A write to window 6 (0xC0–0xDF) stores the byte at that offset in channels 2 and 3 only. A read from window 6 returns channel 2's register.
- R6: Window 7 (0xE0–0xFF) addresses the single common bank. Writes to it change no channel register, and reads from it return the common register.
- R7: Read data is registered. When `rd_en` is high, `rd_data` holds the result and `rd_valid` pulses high for exactly one cycle, starting on the clock after the strobe. `rd_valid` stays low in every cycle that does not follow a read strobe.
- R8: When `wr_en` and `rd_en` are high in the same cycle, the write takes effect first, and the read returns the newly written byte.
- R9: All channels targeted by a group write show the new byte on the parallel outputs after the same clock edge.
- R10: Transfers may be issued on consecutive cycles with no idle cycle between them. Each read returns its own result exactly one cycle later.
- R11: Channel c, offset o is presented on `ch_regs_o[((c*32)+o)*8 +: 8]`. Common offset o is presented on `shared_regs_o[o*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe (valid for a write transfer) |
| rd_en | input | 1 | Read strobe (valid for a read transfer) |
| addr | input | 8 | Register address: [7:5] window, [4:0] offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| ch_regs_o | output | 1024 | All channel registers, flattened |
| shared_regs_o | output | 256 | All common registers, flattened |

## Verification
A write and a read can land in the same cycle at the same address. This case is the one where write-first ordering matters. It matters most in the group windows, where the written set of channels and the channel that supplies the read are chosen by different rules. The bench raises both strobes together in every window: single-channel, each group, and common. Its model applies the write before it forms the expected read byte, and the monitor compares the byte that comes back one cycle later. The parallel buses are then compared in full, to confirm that exactly the listed channels took the byte.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int WIN_W  = 3;

  typedef enum logic [WIN_W-1:0] {
    WIN_CH0 = 3'd0,
    WIN_CH1 = 3'd1,
    WIN_CH2 = 3'd2,
    WIN_CH3 = 3'd3,
    WIN_ALL = 3'd4,
    WIN_LO  = 3'd5,
    WIN_HI  = 3'd6,
    WIN_SHR = 3'd7
  } win_e;

  // channel sets reached by the group windows, and the channel each reads from
  localparam logic [NUM_CH-1:0] GRP_ALL_MASK = 4'b1111;
  localparam logic [NUM_CH-1:0] GRP_LO_MASK  = 4'b0011;
  localparam logic [NUM_CH-1:0] GRP_HI_MASK  = 4'b1100;
  localparam logic [CH_W-1:0]   GRP_ALL_RD   = 2'd0;
  localparam logic [CH_W-1:0]   GRP_LO_RD    = 2'd0;
  localparam logic [CH_W-1:0]   GRP_HI_RD    = 2'd2;

  typedef struct packed {
    logic [NUM_CH-1:0] ch_we;
    logic              sh_we;
    logic              rd_sh;
    logic [CH_W-1:0]   rd_ch;
  } route_t;

endpackage

// File: rtl/chreg_win_decode.sv
module chreg_win_decode
  import chreg_pkg::*;
(
  input  logic [WIN_W-1:0] win_i,
  output route_t           route_o
);

  always_comb begin
    route_o = '0;
    unique case (win_e'(win_i))
      WIN_CH0, WIN_CH1, WIN_CH2, WIN_CH3: begin
        route_o.ch_we = {{(NUM_CH-1){1'b0}}, 1'b1} << win_i[CH_W-1:0];
        route_o.rd_ch = win_i[CH_W-1:0];
      end
      WIN_ALL: begin
        route_o.ch_we = GRP_ALL_MASK;
        route_o.rd_ch = GRP_ALL_RD;
      end
      WIN_LO: begin
        route_o.ch_we = GRP_LO_MASK;
        route_o.rd_ch = GRP_LO_RD;
      end
      WIN_HI: begin
        route_o.ch_we = GRP_HI_MASK;
        route_o.rd_ch = GRP_HI_RD;
      end
      WIN_SHR: begin
        route_o.sh_we = 1'b1;
        route_o.rd_sh = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/chreg_bank.sv
module chreg_bank #(
  parameter int DATA_W = 8,
  parameter int OFFS_W = 5
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we_i,
  input  logic [OFFS_W-1:0]                off_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [(1<<OFFS_W)-1:0][DATA_W-1:0] regs_o
);

  localparam int DEPTH = 1 << OFFS_W;

  logic [DEPTH-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q <= '0;
    end else if (we_i) begin
      regs_q[off_i] <= wdata_i;
    end
  end

  assign regs_o = regs_q;

  // a bank that is not selected keeps every byte
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(regs_q));

endmodule

// File: rtl/chreg_read_port.sv
module chreg_read_port
  import chreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFFS_W = 5
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          rd_en_i,
  input  logic                                          wr_en_i,
  input  logic [OFFS_W-1:0]                             off_i,
  input  logic [DATA_W-1:0]                             wdata_i,
  input  route_t                                        route_i,
  input  logic [NUM_CH-1:0][(1<<OFFS_W)-1:0][DATA_W-1:0] ch_regs_i,
  input  logic [(1<<OFFS_W)-1:0][DATA_W-1:0]            sh_regs_i,
  output logic [DATA_W-1:0]                             rd_data_o,
  output logic                                          rd_valid_o
);

  logic [DATA_W-1:0] stored_byte;
  logic              src_written;
  logic [DATA_W-1:0] next_byte;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  always_comb begin
    if (route_i.rd_sh) begin
      stored_byte = sh_regs_i[off_i];
      src_written = route_i.sh_we;
    end else begin
      stored_byte = ch_regs_i[route_i.rd_ch][off_i];
      src_written = route_i.ch_we[route_i.rd_ch];
    end
    // write-first: a write that hits the read source in this cycle wins
    next_byte = (wr_en_i && src_written) ? wdata_i : stored_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en_i;
      if (rd_en_i) begin
        rd_data_q <= next_byte;
      end
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;

  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);

  assert_rd_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> !rd_valid_o);

endmodule

// File: rtl/chan_regfile.sv
module chan_regfile
  import chreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OFFS_W = 5
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        wr_en,
  input  logic                                        rd_en,
  input  logic [OFFS_W+WIN_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                           wdata,
  output logic [DATA_W-1:0]                           rd_data,
  output logic                                        rd_valid,
  output logic [NUM_CH*(1<<OFFS_W)*DATA_W-1:0]        ch_regs_o,
  output logic [(1<<OFFS_W)*DATA_W-1:0]               shared_regs_o
);

  localparam int DEPTH  = 1 << OFFS_W;
  localparam int ADDR_W = OFFS_W + WIN_W;

  logic [WIN_W-1:0]                           win;
  logic [OFFS_W-1:0]                          off;
  route_t                                     route;
  logic [NUM_CH-1:0][DEPTH-1:0][DATA_W-1:0]   ch_regs;
  logic [DEPTH-1:0][DATA_W-1:0]               sh_regs;

  assign win = addr[ADDR_W-1:OFFS_W];
  assign off = addr[OFFS_W-1:0];

  chreg_win_decode i_decode (
    .win_i   (win),
    .route_o (route)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chreg_bank #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) i_bank (
      .clk     (clk),
      .rst     (rst),
      .we_i    (wr_en && route.ch_we[c]),
      .off_i   (off),
      .wdata_i (wdata),
      .regs_o  (ch_regs[c])
    );
  end

  chreg_bank #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) i_shared (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en && route.sh_we),
    .off_i   (off),
    .wdata_i (wdata),
    .regs_o  (sh_regs)
  );

  chreg_read_port #(.DATA_W(DATA_W), .OFFS_W(OFFS_W)) i_rdport (
    .clk        (clk),
    .rst        (rst),
    .rd_en_i    (rd_en),
    .wr_en_i    (wr_en),
    .off_i      (off),
    .wdata_i    (wdata),
    .route_i    (route),
    .ch_regs_i  (ch_regs),
    .sh_regs_i  (sh_regs),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  assign ch_regs_o     = ch_regs;
  assign shared_regs_o = sh_regs;

  // ---- assertions ----
  logic              all_wr_q;
  logic [OFFS_W-1:0] all_off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      all_wr_q  <= 1'b0;
      all_off_q <= '0;
    end else begin
      all_wr_q  <= wr_en && (win == WIN_W'(WIN_ALL));
      all_off_q <= off;
    end
  end

  for (genvar c = 1; c < NUM_CH; c++) begin : g_chk
    assert_group_same_edge_R9: assert property (@(posedge clk) disable iff (rst)
      all_wr_q |-> (ch_regs[c][all_off_q] == ch_regs[0][all_off_q]));
  end

  assert_common_no_chan_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && win == WIN_W'(WIN_SHR)) |=> $stable(ch_regs));

  assert_write_first_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> (rd_data == $past(wdata)));

endmodule

// File: tb/test_chan_regfile.sv
module test_chan_regfile;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         rd_en = 1'b0;
  logic [7:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rd_data;
  logic         rd_valid;
  logic [1023:0] ch_regs_o;
  logic [255:0]  shared_regs_o;

  always #4 clk = ~clk;

  chan_regfile i_chan_regfile (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .addr          (addr),
    .wdata         (wdata),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .ch_regs_o     (ch_regs_o),
    .shared_regs_o (shared_regs_o)
  );

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 0;

  logic [7:0] m_ch [4][32];
  logic [7:0] m_sh [32];

  typedef struct {
    logic [7:0] data;
    int         due;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] wmask(logic [2:0] w);
    case (w)
      3'd4: return 4'b1111;
      3'd5: return 4'b0011;
      3'd6: return 4'b1100;
      3'd7: return 4'b0000;
      default: return 4'b0001 << w[1:0];
    endcase
  endfunction

  function automatic logic [7:0] model_read(logic [7:0] a);
    case (a[7:5])
      3'd4, 3'd5: return m_ch[0][a[4:0]];
      3'd6:       return m_ch[2][a[4:0]];
      3'd7:       return m_sh[a[4:0]];
      default:    return m_ch[a[6:5]][a[4:0]];
    endcase
  endfunction

  // driver: one transfer per call, on consecutive cycles when called back to back
  task automatic xfer(bit w, bit r, logic [7:0] a, logic [7:0] d, string req);
    exp_t e;
    logic [3:0] m;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (w) begin
      m = wmask(a[7:5]);
      for (int c = 0; c < 4; c++) if (m[c]) m_ch[c][a[4:0]] = d;
      if (a[7:5] == 3'd7) m_sh[a[4:0]] = d;
    end
    if (r) begin
      e.data = model_read(a);
      e.due  = cyc + 1;
      e.req  = req;
      exp_q.push_back(e);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
    end
  endtask

  // full compare of the parallel buses against the model
  task automatic check_bus(string req);
    int bad = 0;
    logic [7:0] got;
    logic [7:0] want;
    string where = "";
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 32; o++)
        if (ch_regs_o[((c*32)+o)*8 +: 8] !== m_ch[c][o] && bad == 0) begin
          bad = 1; got = ch_regs_o[((c*32)+o)*8 +: 8]; want = m_ch[c][o];
          where = $sformatf("ch%0d off%0d", c, o);
        end
    for (int o = 0; o < 32; o++)
      if (shared_regs_o[o*8 +: 8] !== m_sh[o] && bad == 0) begin
        bad = 1; got = shared_regs_o[o*8 +: 8]; want = m_sh[o];
        where = $sformatf("common off%0d", o);
      end
    vectors++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s bus %s: got %02h expected %02h", req, where, got, want);
    end
  endtask

  task automatic check_idle(string req);
    vectors++;
    if (rd_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s rd_valid: got %b expected 0", req, rd_valid);
    end
  endtask

  // monitor: pops expected read results in the cycle they are due
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        vectors++;
        if (rd_valid !== 1'b1 || rd_data !== e.data) begin
          fails++;
          $display("FAIL %s read: got valid=%b data=%02h expected valid=1 data=%02h",
                   e.req, rd_valid, rd_data, e.data);
        end
      end else if (rd_valid === 1'b1) begin
        vectors++;
        fails++;
        $display("FAIL R7 stray rd_valid: got 1 expected 0");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int c = 0; c < 4; c++) for (int o = 0; o < 32; o++) m_ch[c][o] = '0;
    for (int o = 0; o < 32; o++) m_sh[o] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    check_bus("R1");
    check_idle("R1");
    xfer(0, 1, 8'h1F, 8'h00, "R1");
    xfer(0, 1, 8'hFF, 8'h00, "R1");
    idle(2);

    // R2: single channel windows; R11: bus layout
    xfer(1, 0, 8'h25, 8'hA5, "R2"); idle(1); check_bus("R2");
    xfer(1, 0, 8'h00, 8'h01, "R2");
    xfer(1, 0, 8'h5F, 8'hC2, "R11");
    xfer(1, 0, 8'h7E, 8'hD3, "R11"); idle(1); check_bus("R11");
    xfer(0, 1, 8'h25, 8'h00, "R2");
    xfer(0, 1, 8'h05, 8'h00, "R2");
    idle(2); check_idle("R7");

    // R3 / R9: all-channel group
    xfer(1, 0, 8'h83, 8'h3C, "R3"); idle(1); check_bus("R9");
    xfer(1, 0, 8'h03, 8'h11, "R3");
    xfer(0, 1, 8'h83, 8'h00, "R3");
    xfer(0, 1, 8'h63, 8'h00, "R3");
    idle(2);

    // R4: low pair
    xfer(1, 0, 8'hA7, 8'h77, "R4"); idle(1); check_bus("R4");
    xfer(1, 0, 8'h07, 8'h01, "R4");
    xfer(0, 1, 8'hA7, 8'h00, "R4");
    xfer(0, 1, 8'h27, 8'h00, "R4");
    idle(2);

    // R5: high pair, read from channel 2
    xfer(1, 0, 8'hC9, 8'h99, "R5"); idle(1); check_bus("R5");
    xfer(1, 0, 8'h49, 8'h42, "R5");
    xfer(1, 0, 8'h69, 8'h43, "R5");
    xfer(0, 1, 8'hC9, 8'h00, "R5");
    idle(2); check_bus("R5");

    // R6: common bank
    xfer(1, 0, 8'hE4, 8'h5E, "R6"); idle(1); check_bus("R6");
    xfer(0, 1, 8'hE4, 8'h00, "R6");
    xfer(0, 1, 8'h04, 8'h00, "R6");
    idle(2);

    // R8: write and read together in every window kind
    xfer(1, 1, 8'h2A, 8'h61, "R8");
    xfer(1, 1, 8'h8B, 8'h62, "R8");
    xfer(1, 1, 8'hAC, 8'h63, "R8");
    xfer(1, 1, 8'hCD, 8'h64, "R8");
    xfer(1, 1, 8'hEE, 8'h65, "R8");
    idle(1); check_bus("R8");
    idle(1);

    // R10: back-to-back reads across windows
    for (int i = 0; i < 8; i++) xfer(0, 1, 8'((i * 37) + 3), 8'h00, "R10");
    idle(2); check_idle("R7");

    // mixed traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      xfer(lfsr[0] | ~lfsr[1], lfsr[1], lfsr[15:8], lfsr[7:0] ^ 8'(i), "R10");
      if (lfsr[2]) begin
        idle(1); check_bus("R2");
      end
    end
    idle(3); check_bus("R9"); check_idle("R7");

    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 pending reads: got %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule